// File: doc/BRIEF.md
# Windowed Trap Entry Sequencer

This block performs the hardware side of taking a trap on a processor whose integer registers are organised as a circular set of overlapping windows. When a trap request arrives, the unit samples the trap number, the two fetch addresses and the processor status fields. One cycle later it publishes the new architectural state in a single step. The window pointer steps back by one position and wraps around the ring. The interrupted program counter and next program counter are written into two fixed registers of the new window. Supervisor mode is entered, the old mode is remembered, further traps are masked, and the trap table address is built from the base field and the trap number. Fetch is then redirected to that address.

A request made while traps are masked cannot be serviced. The unit then enters a halted error condition. It stays there until reset and ignores every later request. Returning from a trap is handled elsewhere.

Top module: `trap_entry_unit`

## Requirements
- R1: After synchronous reset, `idle` is 1, `done`, `err_halt` and `rf_we` are 0, and every state output (`cwp_out`, `sup_out`, `prev_sup_out`, `trap_en_out`, `tbr_out`, `pc_out`, `npc_out`) is 0.
- R2: A request is accepted on a rising edge only when `idle` is 1. A request held high on the edge right after acceptance is not accepted again, and it yields exactly one completion.
- R3: For a request accepted on edge k, `done` is high for exactly the one cycle that follows edge k+1, and it is low in the cycle between edges k and k+1.
- R4: In the completion cycle, `cwp_out` equals `cwp_in` minus one, modulo NWIN (default 8, a power of two). A pointer of 0 gives NWIN-1.
- R5: `rf_we` is high only in the completion cycle. In that cycle `rf_win` equals the new window pointer. `rf_pc_idx` is 17 and carries the sampled program counter on `rf_pc_data`. `rf_npc_idx` is 18 and carries the sampled next program counter on `rf_npc_data`.
- R6: In the completion cycle, `prev_sup_out` equals the sampled `sup_in`, `sup_out` is 1 and `trap_en_out` is 0.
- R7: In the completion cycle, `tbr_out` keeps bits 31:12 of the sampled `tbr_in`, holds the trap number in bits 11:4, and has bits 3:0 at zero.
- R8: In the completion cycle, `pc_out` equals `tbr_out` and `npc_out` equals `tbr_out + 4`.
- R9: A request seen while `idle` is 1 and `trap_en_in` is 0 sets `err_halt` on that edge. It never produces `done` or `rf_we`. All state outputs keep their values, and later requests are ignored until reset.
- R10: The result depends only on the inputs sampled on the accepting edge. Input changes after that edge have no effect on the completion.
- R11: State outputs hold their value in every cycle that is not a completion cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trap_req | input | 1 | Trap request |
| trap_num | input | 8 | Trap number |
| pc_in | input | 32 | Program counter at the trap |
| npc_in | input | 32 | Next program counter at the trap |
| cwp_in | input | $clog2(NWIN) | Current window pointer |
| sup_in | input | 1 | Current supervisor bit |
| trap_en_in | input | 1 | Current trap-enable bit |
| tbr_in | input | 32 | Current trap base register |
| idle | output | 1 | Unit can accept a request |
| done | output | 1 | One-cycle completion pulse |
| err_halt | output | 1 | Sticky error state |
| cwp_out | output | $clog2(NWIN) | New window pointer |
| sup_out | output | 1 | New supervisor bit |
| prev_sup_out | output | 1 | New previous-supervisor bit |
| trap_en_out | output | 1 | New trap-enable bit |
| tbr_out | output | 32 | New trap base register |
| pc_out | output | 32 | Redirected program counter |
| npc_out | output | 32 | Redirected next program counter |
| rf_we | output | 1 | Register-file write strobe for both save ports |
| rf_win | output | $clog2(NWIN) | Window written by both save ports |
| rf_pc_idx | output | 5 | Register index for the saved program counter |
| rf_pc_data | output | 32 | Saved program counter |
| rf_npc_idx | output | 5 | Register index for the saved next program counter |
| rf_npc_data | output | 32 | Saved next program counter |

## Verification
The bench starts a trap from window 0. A design that subtracts without wrapping, or that keeps the pointer, would then report a window outside the ring or the old window. It holds a request across the busy cycle. A unit that re-arms too early would emit two completions and save twice. It scrambles every input right after acceptance, which exposes a unit that computes from live inputs instead of the sampled copy. It also issues a request with traps masked. A faulty unit would still redirect fetch or write registers there, instead of halting quietly and staying halted until reset.

// File: rtl/trap_entry_pkg.sv
package trap_entry_pkg;

    localparam int XLEN         = 32;
    localparam int TT_W         = 8;
    localparam int TT_LSB       = 4;
    localparam int BASE_LSB     = TT_LSB + TT_W;
    localparam int BASE_W       = XLEN - BASE_LSB;
    localparam int REG_IDX_W    = 5;
    localparam int PC_SAVE_IDX  = 17;
    localparam int NPC_SAVE_IDX = 18;
    localparam int FETCH_STEP   = 4;

    typedef enum logic [1:0] {
        TE_IDLE   = 2'd0,
        TE_COMMIT = 2'd1,
        TE_HALT   = 2'd2
    } te_state_e;

    // Snapshot taken on the accepting edge
    typedef struct packed {
        logic [XLEN-1:0]   pc;
        logic [XLEN-1:0]   npc;
        logic [BASE_W-1:0] tbr_base;
        logic [TT_W-1:0]   tt;
        logic              sup;
    } trap_ctx_t;

    // Mode bits published on completion
    typedef struct packed {
        logic sup;
        logic prev_sup;
        logic trap_en;
    } mode_bits_t;

    // Fetch redirection result
    typedef struct packed {
        logic [XLEN-1:0] tbr;
        logic [XLEN-1:0] pc;
        logic [XLEN-1:0] npc;
    } vector_t;

    function automatic logic [XLEN-1:0] compose_tbr(
        input logic [BASE_W-1:0] base,
        input logic [TT_W-1:0]   tt
    );
        return {base, tt, {TT_LSB{1'b0}}};
    endfunction

    function automatic mode_bits_t enter_mode(input logic old_sup);
        mode_bits_t m;
        m.sup      = 1'b1;
        m.prev_sup = old_sup;
        m.trap_en  = 1'b0;
        return m;
    endfunction

endpackage

// File: rtl/trap_window_step.sv
module trap_window_step #(
    parameter int NWIN  = 8,
    parameter int CWP_W = $clog2(NWIN)
) (
    input  logic [CWP_W-1:0] cur,
    output logic [CWP_W-1:0] nxt
);

    localparam logic [CWP_W-1:0] LAST_WIN = CWP_W'(NWIN - 1);

    generate
        if ((NWIN & (NWIN - 1)) == 0) begin : g_pow2
            // Width equals log2(NWIN): unsigned underflow is the wrap
            assign nxt = cur - 1'b1;
        end else begin : g_generic
            assign nxt = (cur == '0) ? LAST_WIN : cur - 1'b1;
        end
    endgenerate

    always_comb begin
        assert_wrap_R4: assert ((cur != '0) || (nxt == LAST_WIN))
            else $error("window step did not wrap to the last window");
    end

endmodule

// File: rtl/trap_vector_form.sv
module trap_vector_form
    import trap_entry_pkg::*;
(
    input  logic [BASE_W-1:0] base,
    input  logic [TT_W-1:0]   tt,
    output vector_t           vec
);

    always_comb begin
        vec.tbr = compose_tbr(base, tt);
        vec.pc  = vec.tbr;
        vec.npc = vec.tbr + XLEN'(FETCH_STEP);
    end

endmodule

// File: rtl/trap_entry_fsm.sv
module trap_entry_fsm
    import trap_entry_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req,
    input  logic trap_en,
    output logic accept,
    output logic commit,
    output logic idle,
    output logic halted,
    output logic done
);

    te_state_e state_q, state_d;

    assign idle   = (state_q == TE_IDLE);
    assign commit = (state_q == TE_COMMIT);
    assign halted = (state_q == TE_HALT);
    assign accept = idle && req && trap_en;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TE_IDLE: begin
                if (req && trap_en)       state_d = TE_COMMIT;
                else if (req && !trap_en) state_d = TE_HALT;
            end
            TE_COMMIT: state_d = TE_IDLE;
            TE_HALT:   state_d = TE_HALT;
            default:   state_d = TE_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= TE_IDLE;
            done    <= 1'b0;
        end else begin
            state_q <= state_d;
            done    <= commit;
        end
    end

    assert_done_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        done |=> !done)
        else $error("done held longer than one cycle");

    assert_halt_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted)
        else $error("error state left without reset");

    assert_accept_leads_commit_R2: assert property (@(posedge clk) disable iff (rst)
        accept |=> (commit && !idle))
        else $error("accepted request did not enter commit");

endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
    import trap_entry_pkg::*;
#(
    parameter int NWIN  = 8,
    parameter int CWP_W = $clog2(NWIN)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 trap_req,
    input  logic [TT_W-1:0]      trap_num,
    input  logic [XLEN-1:0]      pc_in,
    input  logic [XLEN-1:0]      npc_in,
    input  logic [CWP_W-1:0]     cwp_in,
    input  logic                 sup_in,
    input  logic                 trap_en_in,
    input  logic [XLEN-1:0]      tbr_in,
    output logic                 idle,
    output logic                 done,
    output logic                 err_halt,
    output logic [CWP_W-1:0]     cwp_out,
    output logic                 sup_out,
    output logic                 prev_sup_out,
    output logic                 trap_en_out,
    output logic [XLEN-1:0]      tbr_out,
    output logic [XLEN-1:0]      pc_out,
    output logic [XLEN-1:0]      npc_out,
    output logic                 rf_we,
    output logic [CWP_W-1:0]     rf_win,
    output logic [REG_IDX_W-1:0] rf_pc_idx,
    output logic [XLEN-1:0]      rf_pc_data,
    output logic [REG_IDX_W-1:0] rf_npc_idx,
    output logic [XLEN-1:0]      rf_npc_data
);

    logic       accept, commit;
    trap_ctx_t  ctx_q;
    logic [CWP_W-1:0] cwp_q, cwp_next;
    vector_t    vec;
    mode_bits_t mode_next;

    trap_entry_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .req     (trap_req),
        .trap_en (trap_en_in),
        .accept  (accept),
        .commit  (commit),
        .idle    (idle),
        .halted  (err_halt),
        .done    (done)
    );

    // Snapshot on acceptance; later input changes are ignored
    always_ff @(posedge clk) begin
        if (rst) begin
            ctx_q <= '0;
            cwp_q <= '0;
        end else if (accept) begin
            ctx_q.pc       <= pc_in;
            ctx_q.npc      <= npc_in;
            ctx_q.tbr_base <= tbr_in[XLEN-1:BASE_LSB];
            ctx_q.tt       <= trap_num;
            ctx_q.sup      <= sup_in;
            cwp_q          <= cwp_in;
        end
    end

    // tbr_in low bits are replaced by the trap number and zeros
    logic unused_tbr_low;
    assign unused_tbr_low = ^tbr_in[BASE_LSB-1:0];

    trap_window_step #(.NWIN(NWIN), .CWP_W(CWP_W)) u_step (
        .cur (cwp_q),
        .nxt (cwp_next)
    );

    trap_vector_form u_vec (
        .base (ctx_q.tbr_base),
        .tt   (ctx_q.tt),
        .vec  (vec)
    );

    assign mode_next = enter_mode(ctx_q.sup);

    // Architectural state and register-file strobes, published together
    always_ff @(posedge clk) begin
        if (rst) begin
            cwp_out      <= '0;
            sup_out      <= 1'b0;
            prev_sup_out <= 1'b0;
            trap_en_out  <= 1'b0;
            tbr_out      <= '0;
            pc_out       <= '0;
            npc_out      <= '0;
            rf_we        <= 1'b0;
            rf_win       <= '0;
            rf_pc_data   <= '0;
            rf_npc_data  <= '0;
        end else begin
            rf_we <= commit;
            if (commit) begin
                cwp_out      <= cwp_next;
                sup_out      <= mode_next.sup;
                prev_sup_out <= mode_next.prev_sup;
                trap_en_out  <= mode_next.trap_en;
                tbr_out      <= vec.tbr;
                pc_out       <= vec.pc;
                npc_out      <= vec.npc;
                rf_win       <= cwp_next;
                rf_pc_data   <= ctx_q.pc;
                rf_npc_data  <= ctx_q.npc;
            end
        end
    end

    assign rf_pc_idx  = REG_IDX_W'(PC_SAVE_IDX);
    assign rf_npc_idx = REG_IDX_W'(NPC_SAVE_IDX);

    assert_we_with_done_R5: assert property (@(posedge clk) disable iff (rst)
        rf_we == done)
        else $error("write strobe and done disagree");

    assert_win_matches_R5: assert property (@(posedge clk) disable iff (rst)
        rf_we |-> (rf_win == cwp_out))
        else $error("write window differs from new pointer");

    assert_entry_mode_R6: assert property (@(posedge clk) disable iff (rst)
        done |-> (sup_out && !trap_en_out))
        else $error("mode bits wrong on completion");

    assert_fetch_pair_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> ((pc_out == tbr_out) && (npc_out == pc_out + XLEN'(FETCH_STEP))))
        else $error("fetch redirection inconsistent");

    assert_halt_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        err_halt |-> (!done && !rf_we))
        else $error("activity while halted");

    assert_state_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !commit |=> ($stable(cwp_out) && $stable(tbr_out) && $stable(pc_out)
                     && $stable(sup_out) && $stable(trap_en_out)))
        else $error("state changed outside completion");

endmodule

// File: tb/trap_entry_unit_tb.sv
module trap_entry_unit_tb_top;
    import trap_entry_pkg::*;

    localparam int NWIN  = 8;
    localparam int CWP_W = $clog2(NWIN);

    logic clk = 1'b0;
    logic rst;
    logic trap_req;
    logic [TT_W-1:0] trap_num;
    logic [XLEN-1:0] pc_in, npc_in, tbr_in;
    logic [CWP_W-1:0] cwp_in;
    logic sup_in, trap_en_in;
    logic idle, done, err_halt;
    logic [CWP_W-1:0] cwp_out, rf_win;
    logic sup_out, prev_sup_out, trap_en_out, rf_we;
    logic [XLEN-1:0] tbr_out, pc_out, npc_out, rf_pc_data, rf_npc_data;
    logic [REG_IDX_W-1:0] rf_pc_idx, rf_npc_idx;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    trap_entry_unit #(.NWIN(NWIN)) dut_i (
        .clk(clk), .rst(rst), .trap_req(trap_req), .trap_num(trap_num),
        .pc_in(pc_in), .npc_in(npc_in), .cwp_in(cwp_in), .sup_in(sup_in),
        .trap_en_in(trap_en_in), .tbr_in(tbr_in), .idle(idle), .done(done),
        .err_halt(err_halt), .cwp_out(cwp_out), .sup_out(sup_out),
        .prev_sup_out(prev_sup_out), .trap_en_out(trap_en_out), .tbr_out(tbr_out),
        .pc_out(pc_out), .npc_out(npc_out), .rf_we(rf_we), .rf_win(rf_win),
        .rf_pc_idx(rf_pc_idx), .rf_pc_data(rf_pc_data), .rf_npc_idx(rf_npc_idx),
        .rf_npc_data(rf_npc_data)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic scramble();
        trap_num   = 8'hFF;
        pc_in      = 32'hDEAD_BEEF;
        npc_in     = 32'hBAAD_F00D;
        cwp_in     = 3'd3;
        sup_in     = ~sup_in;
        tbr_in     = 32'h5555_5555;
    endtask

    // One trap from request to the cycle after completion
    task automatic run_trap(input logic [7:0] tt, input logic [31:0] pc,
                            input logic [31:0] npc, input logic [CWP_W-1:0] cwp,
                            input logic s, input logic [31:0] tbr);
        logic [CWP_W-1:0] exp_cwp;
        logic [31:0] exp_tbr;
        exp_cwp = (cwp == 0) ? CWP_W'(NWIN - 1) : cwp - 1'b1;
        exp_tbr = {tbr[31:12], tt, 4'h0};
        @(negedge clk);
        trap_req = 1'b1; trap_num = tt; pc_in = pc; npc_in = npc;
        cwp_in = cwp; sup_in = s; trap_en_in = 1'b1; tbr_in = tbr;
        chk(idle == 1'b1, "R2", "idle before request", 32'(idle), 32'd1);
        @(posedge clk);
        @(negedge clk);
        trap_req = 1'b0;
        scramble();                                   // R10
        chk(done == 1'b0, "R3", "done early", 32'(done), 32'd0);
        chk(rf_we == 1'b0, "R5", "early write", 32'(rf_we), 32'd0);
        @(posedge clk);
        @(negedge clk);
        chk(done == 1'b1, "R3", "done pulse", 32'(done), 32'd1);
        chk(cwp_out == exp_cwp, "R4", "window", 32'(cwp_out), 32'(exp_cwp));
        chk(rf_we == 1'b1, "R5", "write strobe", 32'(rf_we), 32'd1);
        chk(rf_win == exp_cwp, "R5", "write window", 32'(rf_win), 32'(exp_cwp));
        chk(rf_pc_idx == 5'd17, "R5", "pc index", 32'(rf_pc_idx), 32'd17);
        chk(rf_npc_idx == 5'd18, "R5", "npc index", 32'(rf_npc_idx), 32'd18);
        chk(rf_pc_data == pc, "R10", "saved pc", rf_pc_data, pc);
        chk(rf_npc_data == npc, "R10", "saved npc", rf_npc_data, npc);
        chk(prev_sup_out == s, "R6", "prev sup", 32'(prev_sup_out), 32'(s));
        chk(sup_out == 1'b1, "R6", "sup", 32'(sup_out), 32'd1);
        chk(trap_en_out == 1'b0, "R6", "trap enable", 32'(trap_en_out), 32'd0);
        chk(tbr_out == exp_tbr, "R7", "tbr", tbr_out, exp_tbr);
        chk(pc_out == exp_tbr, "R8", "pc redirect", pc_out, exp_tbr);
        chk(npc_out == exp_tbr + 4, "R8", "npc redirect", npc_out, exp_tbr + 4);
        @(posedge clk);
        @(negedge clk);
        chk(done == 1'b0, "R3", "done drop", 32'(done), 32'd0);
        chk(rf_we == 1'b0, "R5", "write drop", 32'(rf_we), 32'd0);
        chk(tbr_out == exp_tbr, "R11", "tbr held", tbr_out, exp_tbr);
        chk(cwp_out == exp_cwp, "R11", "window held", 32'(cwp_out), 32'(exp_cwp));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; trap_req = 1'b0; trap_en_in = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic test_reset();
        do_reset();
        chk(idle == 1'b1, "R1", "idle", 32'(idle), 32'd1);
        chk(done == 1'b0 && rf_we == 1'b0 && err_halt == 1'b0, "R1", "flags",
            {29'd0, done, rf_we, err_halt}, 32'd0);
        chk(cwp_out == 0 && !sup_out && !prev_sup_out && !trap_en_out, "R1", "mode",
            {28'd0, 1'b0, sup_out, prev_sup_out, trap_en_out}, 32'd0);
        chk(tbr_out == 0 && pc_out == 0 && npc_out == 0, "R1", "addresses",
            tbr_out | pc_out | npc_out, 32'd0);
    endtask

    task automatic test_busy_ignore();
        int dones = 0;
        @(negedge clk);
        trap_req = 1'b1; trap_num = 8'h11; pc_in = 32'h100; npc_in = 32'h104;
        cwp_in = 3'd2; sup_in = 1'b1; trap_en_in = 1'b1; tbr_in = 32'h4000_0000;
        @(posedge clk);                // accepted
        @(posedge clk);                // busy edge: must be ignored
        @(negedge clk);
        trap_req = 1'b0;
        if (done) dones++;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (done) dones++;
        end
        chk(dones == 1, "R2", "completions for held request", 32'(dones), 32'd1);
        chk(cwp_out == 3'd1, "R2", "single window step", 32'(cwp_out), 32'd1);
    endtask

    task automatic test_error();
        logic [31:0] snap_tbr, snap_pc;
        logic [CWP_W-1:0] snap_cwp;
        int acts = 0;
        snap_tbr = tbr_out; snap_pc = pc_out; snap_cwp = cwp_out;
        @(negedge clk);
        trap_req = 1'b1; trap_en_in = 1'b0; trap_num = 8'h22;
        tbr_in = 32'h7777_0000; cwp_in = 3'd6;
        @(posedge clk);
        @(negedge clk);
        trap_req = 1'b0;
        chk(err_halt == 1'b1, "R9", "halt raised", 32'(err_halt), 32'd1);
        chk(idle == 1'b0, "R9", "not idle", 32'(idle), 32'd0);
        @(negedge clk);
        trap_req = 1'b1; trap_en_in = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (done || rf_we) acts++;
        end
        trap_req = 1'b0;
        chk(acts == 0, "R9", "activity while halted", 32'(acts), 32'd0);
        chk(err_halt == 1'b1, "R9", "halt sticky", 32'(err_halt), 32'd1);
        chk(tbr_out == snap_tbr, "R9", "tbr unchanged", tbr_out, snap_tbr);
        chk(pc_out == snap_pc, "R9", "pc unchanged", pc_out, snap_pc);
        chk(cwp_out == snap_cwp, "R9", "window unchanged", 32'(cwp_out), 32'(snap_cwp));
        do_reset();
        chk(err_halt == 1'b0, "R1", "halt cleared by reset", 32'(err_halt), 32'd0);
    endtask

    initial begin
        rst = 1'b1; trap_req = 1'b0; trap_num = '0; pc_in = '0; npc_in = '0;
        cwp_in = '0; sup_in = 1'b0; trap_en_in = 1'b1; tbr_in = '0;
        test_reset();
        run_trap(8'h05, 32'h0000_1000, 32'h0000_1004, 3'd5, 1'b0, 32'hA000_0ABC);
        run_trap(8'h80, 32'h2000_0040, 32'h2000_0044, 3'd0, 1'b1, 32'hFFFF_F000);
        run_trap(8'hFF, 32'h0000_0008, 32'h0000_0100, 3'd7, 1'b0, 32'h1234_5FFF);
        run_trap(8'h00, 32'hFFFF_FFFC, 32'h0000_0000, 3'd1, 1'b1, 32'h0000_0000);
        test_busy_ignore();
        test_error();
        run_trap(8'h3C, 32'h0BAD_0000, 32'h0BAD_0004, 3'd4, 1'b1, 32'hC0DE_0000);
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule